// File: doc/BRIEF.md
# Posit field decoder

This block unpacks a posit word, whose field boundaries move from word to word, into fixed-width fields that arithmetic logic downstream can use directly. The total width `N` and the largest exponent width `ES` are parameters. A negative word is first brought to its magnitude by two's complement. The decoder then measures the run of equal bits that follows the sign. That run sets the regime, and the bits left after it become the exponent and then the fraction.

Each accepted word produces one result exactly one clock later. The result holds the sign, a signed regime, the exponent bits, and a mantissa that is left-aligned with an explicit leading one, together with a count of the fraction bits that are really present. It also holds a combined binary scale. Two patterns are flagged instead of decoded: the all-zero word and the exception word. There is no handshake: a qualifier goes in with the word and a qualifier comes out with the result.

Top module: `posit_unpack`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low after a cycle with `in_valid` low; the latency is exactly one clock.
- R2: An all-zero word sets `out_zero`. `out_exc`, `out_sign`, `out_regime`, `out_exp`, `out_mant`, `out_flen` and `out_scale` are then all zero.
- R3: A word with only its most significant bit set sets `out_exc`. Every other output field is then zero, `out_sign` included.
- R4: `out_sign` is the word's most significant bit. A negative word is decoded from its two's complement, so it gives the same regime, exponent and mantissa as its negation.
- R5: With the magnitude's bit N-2 equal to 1, a run of m ones starting at bit N-2 gives a regime of m-1.
- R6: With the magnitude's bit N-2 equal to 0, a run of m zeros starting at bit N-2 gives a regime of -m.
- R7: A run that reaches bit 0 without an opposite terminating bit takes every bit below the sign. The exponent, the fraction bits and `out_flen` are then zero.
- R8: `out_exp` holds the ES bits that follow the terminating bit, most significant first. When fewer than ES bits remain, the missing low bits read as zero. When ES is 0 the port is one bit wide and reads zero.
- R9: `out_mant` has width FW+1 with FW = max(N-3-ES, 1). Bit FW is a constant one and the remaining fraction bits follow it left-aligned, with zeros below them. `out_flen` is the number of fraction bits present, max(N-1-(m+1)-ES, 0).
- R10: `out_scale` equals regime·2^ES + exponent, as a signed value.
- R11: In a cycle without `in_valid`, every output field keeps the value of the last accepted result.
- R12: While `rst` is high, `out_valid` and every output field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_word` |
| in_word | input | N | Posit word to decode |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_zero | output | 1 | Word was zero |
| out_exc | output | 1 | Word was the exception pattern |
| out_sign | output | 1 | Sign of the word |
| out_regime | output | clog2(N)+1 | Signed regime value |
| out_exp | output | max(ES,1) | Exponent bits |
| out_mant | output | FW+1 | Hidden one followed by left-aligned fraction |
| out_flen | output | clog2(FW+1) | Number of fraction bits present |
| out_scale | output | clog2(N)+ES+2 | Signed regime·2^ES + exponent |

## Verification
The assertions assume that `in_valid` and `in_word` are driven to known values in every cycle after reset, and that `in_valid` stays low during reset. They also assume that the two special patterns reach the decoder only as whole words, never as a mix of fields. The stimulus applies every code of the 8-bit types and random 16-bit words, which include both special patterns, negative words and run lengths from one bit up to the unterminated case. It moves inputs only on falling edges, holds them at defined values from the first cycle, and leaves gaps in `in_valid` so that the holding behaviour gets exercised.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

  // Signed regime width: holds -(N-1) .. N-2
  function automatic int reg_w(input int n);
    return $clog2(n) + 1;
  endfunction

  // Widest fraction field the type can carry
  function automatic int frac_w(input int n, input int es);
    return (n - 3 - es >= 1) ? (n - 3 - es) : 1;
  endfunction

  function automatic int len_w(input int n, input int es);
    return $clog2(frac_w(n, es) + 1);
  endfunction

  function automatic int exp_w(input int es);
    return (es > 0) ? es : 1;
  endfunction

  function automatic int scale_w(input int n, input int es);
    return reg_w(n) + es + 1;
  endfunction

endpackage

// File: rtl/posit_magnitude.sv
module posit_magnitude #(
  parameter int N = 16
) (
  input  logic [N-1:0] word,
  output logic [N-2:0] body,
  output logic         neg,
  output logic         is_zero,
  output logic         is_exc
);

  assign neg     = word[N-1];
  assign is_zero = (word == '0);
  assign is_exc  = word[N-1] && (word[N-2:0] == '0);

  // Low N-1 bits of the two's complement equal the two's complement of the low bits
  assign body = neg ? ((~word[N-2:0]) + {{(N-2){1'b0}}, 1'b1}) : word[N-2:0];

endmodule

// File: rtl/posit_regime_scan.sv
module posit_regime_scan #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  logic [N-2:0]  body,
  output logic          pol,
  output logic [CW-1:0] run
);

  localparam int BW = N - 1;

  logic [BW-1:0] lead;
  logic          stop;

  assign pol  = body[BW-1];
  // Fold both polarities into a leading-ones count
  assign lead = pol ? body : ~body;

  always_comb begin
    run  = '0;
    stop = 1'b0;
    for (int i = BW - 1; i >= 0; i--) begin
      if (!stop && lead[i]) run = run + CW'(1);
      else                  stop = 1'b1;
    end
  end

endmodule

// File: rtl/posit_field_split.sv
module posit_field_split #(
  parameter int N  = 16,
  parameter int ES = 1,
  parameter int CW = 5,
  parameter int FW = 12,
  parameter int LW = 4,
  parameter int EW = 1
) (
  input  logic [N-2:0]  body,
  input  logic [CW-1:0] run,
  output logic [EW-1:0] exp_bits,
  output logic [FW-1:0] frac,
  output logic [LW-1:0] flen
);

  localparam int BW = N - 1;

  logic [CW-1:0] used;
  logic [BW-1:0] rem;
  int            rest;

  // Run plus terminator, capped when the run reaches the last bit
  assign used = (run < CW'(BW)) ? run + CW'(1) : CW'(BW);
  assign rem  = body << used;

  always_comb begin
    rest = BW - int'(used) - ES;
    flen = (rest > 0) ? LW'(rest) : '0;
  end

  generate
    if (ES == 0) begin : g_no_exp
      assign exp_bits = '0;
      assign frac     = FW'(rem >> (BW - FW));
    end else begin : g_exp
      assign exp_bits = EW'(rem >> (BW - ES));
      assign frac     = FW'((rem << ES) >> (BW - FW));
    end
  endgenerate

endmodule

// File: rtl/posit_unpack.sv
module posit_unpack #(
  parameter int N  = 16,
  parameter int ES = 1
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          in_valid,
  input  logic [N-1:0]                                  in_word,
  output logic                                          out_valid,
  output logic                                          out_zero,
  output logic                                          out_exc,
  output logic                                          out_sign,
  output logic signed [posit_dec_pkg::reg_w(N)-1:0]     out_regime,
  output logic [posit_dec_pkg::exp_w(ES)-1:0]           out_exp,
  output logic [posit_dec_pkg::frac_w(N, ES):0]         out_mant,
  output logic [posit_dec_pkg::len_w(N, ES)-1:0]        out_flen,
  output logic signed [posit_dec_pkg::scale_w(N, ES)-1:0] out_scale
);

  localparam int RW = posit_dec_pkg::reg_w(N);
  localparam int FW = posit_dec_pkg::frac_w(N, ES);
  localparam int LW = posit_dec_pkg::len_w(N, ES);
  localparam int EW = posit_dec_pkg::exp_w(ES);
  localparam int SW = posit_dec_pkg::scale_w(N, ES);

  logic [N-2:0]          body;
  logic                  neg, is_zero, is_exc, special;
  logic                  pol;
  logic [RW-1:0]         run;
  logic [EW-1:0]         exp_c;
  logic [FW-1:0]         frac_c;
  logic [LW-1:0]         flen_c;
  logic signed [RW-1:0]  regime_c;
  logic signed [SW-1:0]  scale_c;

  posit_magnitude #(.N(N)) u_mag (
    .word(in_word), .body(body), .neg(neg), .is_zero(is_zero), .is_exc(is_exc)
  );

  posit_regime_scan #(.N(N), .CW(RW)) u_scan (
    .body(body), .pol(pol), .run(run)
  );

  posit_field_split #(.N(N), .ES(ES), .CW(RW), .FW(FW), .LW(LW), .EW(EW)) u_split (
    .body(body), .run(run), .exp_bits(exp_c), .frac(frac_c), .flen(flen_c)
  );

  assign special  = is_zero | is_exc;
  assign regime_c = pol ? $signed(run - RW'(1)) : -$signed(run);
  assign scale_c  = (SW'(regime_c) <<< ES) + SW'($signed({1'b0, exp_c}));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_zero   <= 1'b0;
      out_exc    <= 1'b0;
      out_sign   <= 1'b0;
      out_regime <= '0;
      out_exp    <= '0;
      out_mant   <= '0;
      out_flen   <= '0;
      out_scale  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_zero <= is_zero;
        out_exc  <= is_exc;
        if (special) begin
          out_sign   <= 1'b0;
          out_regime <= '0;
          out_exp    <= '0;
          out_mant   <= '0;
          out_flen   <= '0;
          out_scale  <= '0;
        end else begin
          out_sign   <= neg;
          out_regime <= regime_c;
          out_exp    <= exp_c;
          out_mant   <= {1'b1, frac_c};
          out_flen   <= flen_c;
          out_scale  <= scale_c;
        end
      end
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == '0) |=> (out_zero && !out_exc && out_mant == '0 && out_scale == '0));
  // R3
  exc_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == {1'b1, {(N-1){1'b0}}}) |=> (out_exc && !out_zero && !out_sign));
  // R5
  regime_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_zero && !out_exc) |-> (out_regime >= -(N-1) && out_regime <= N-2));
  // R9
  hidden_one_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_zero && !out_exc) |-> (out_mant[FW] && out_flen <= LW'(FW)));
  // R10
  scale_sign_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_scale < 0) == (out_regime < 0)));
  // R11
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_scale) && $stable(out_mant) && $stable(out_flen)));

endmodule

// File: tb/sim_posit_unpack.sv
module sim_posit_unpack;
  import posit_dec_pkg::*;

  typedef struct packed {
    logic   zero;
    logic   exc;
    logic   sign;
    logic   unterm;
    longint regime;
    longint expo;
    longint mant;
    longint flen;
    longint scale;
  } ref_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b0;
  logic [15:0] w16 = '0;
  logic [7:0]  w8 = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit          applied_v = 1'b0;
  logic [15:0] applied16 = '0;
  logic [7:0]  applied8 = '0;
  ref_t        hold [4];

  always #5 clk = ~clk;

  // u0: N=16 ES=3
  logic v0, z0, e0, s0;
  logic signed [reg_w(16)-1:0]     r0;
  logic [exp_w(3)-1:0]             x0;
  logic [frac_w(16,3):0]           m0;
  logic [len_w(16,3)-1:0]          l0;
  logic signed [scale_w(16,3)-1:0] c0;
  posit_unpack #(.N(16), .ES(3)) u0 (.clk(clk), .rst(rst), .in_valid(vin), .in_word(w16),
    .out_valid(v0), .out_zero(z0), .out_exc(e0), .out_sign(s0), .out_regime(r0),
    .out_exp(x0), .out_mant(m0), .out_flen(l0), .out_scale(c0));

  // u1: N=8 ES=0
  logic v1, z1, e1, s1;
  logic signed [reg_w(8)-1:0]     r1;
  logic [exp_w(0)-1:0]            x1;
  logic [frac_w(8,0):0]           m1;
  logic [len_w(8,0)-1:0]          l1;
  logic signed [scale_w(8,0)-1:0] c1;
  posit_unpack #(.N(8), .ES(0)) u1 (.clk(clk), .rst(rst), .in_valid(vin), .in_word(w8),
    .out_valid(v1), .out_zero(z1), .out_exc(e1), .out_sign(s1), .out_regime(r1),
    .out_exp(x1), .out_mant(m1), .out_flen(l1), .out_scale(c1));

  // u2: N=8 ES=1
  logic v2, z2, e2, s2;
  logic signed [reg_w(8)-1:0]     r2;
  logic [exp_w(1)-1:0]            x2;
  logic [frac_w(8,1):0]           m2;
  logic [len_w(8,1)-1:0]          l2;
  logic signed [scale_w(8,1)-1:0] c2;
  posit_unpack #(.N(8), .ES(1)) u2 (.clk(clk), .rst(rst), .in_valid(vin), .in_word(w8),
    .out_valid(v2), .out_zero(z2), .out_exc(e2), .out_sign(s2), .out_regime(r2),
    .out_exp(x2), .out_mant(m2), .out_flen(l2), .out_scale(c2));

  // u3: N=8 ES=2
  logic v3, z3, e3, s3;
  logic signed [reg_w(8)-1:0]     r3;
  logic [exp_w(2)-1:0]            x3;
  logic [frac_w(8,2):0]           m3;
  logic [len_w(8,2)-1:0]          l3;
  logic signed [scale_w(8,2)-1:0] c3;
  posit_unpack #(.N(8), .ES(2)) u3 (.clk(clk), .rst(rst), .in_valid(vin), .in_word(w8),
    .out_valid(v3), .out_zero(z3), .out_exc(e3), .out_sign(s3), .out_regime(r3),
    .out_exp(x3), .out_mant(m3), .out_flen(l3), .out_scale(c3));

  // Behavioural decoder written straight from the requirements
  function automatic ref_t ref_dec(input longint unsigned word, input int n, input int es);
    ref_t r;
    longint unsigned x, mask, f;
    int pos, m, fw;
    bit r0b;
    r = '0;
    fw = (n - 3 - es >= 1) ? (n - 3 - es) : 1;
    mask = (64'd1 << n) - 1;
    x = word & mask;
    if (x == 0) begin r.zero = 1'b1; return r; end
    if (x == (64'd1 << (n - 1))) begin r.exc = 1'b1; return r; end
    r.sign = x[n-1];
    if (r.sign) x = (~x + 1) & mask;
    pos = n - 2;
    r0b = x[pos];
    m = 0;
    while (pos >= 0 && x[pos] == r0b) begin m++; pos--; end
    r.unterm = (pos < 0);
    if (pos >= 0) pos--;
    r.regime = r0b ? (m - 1) : -m;
    for (int j = 0; j < es; j++) begin
      r.expo = r.expo * 2 + ((pos >= 0) ? longint'(x[pos]) : 0);
      if (pos >= 0) pos--;
    end
    r.flen = pos + 1;
    f = x & ((64'd1 << (pos + 1)) - 1);
    r.mant = longint'((64'd1 << fw) | (f << (fw - r.flen)));
    r.scale = r.regime * (longint'(1) << es) + r.expo;
    return r;
  endfunction

  task automatic cmp(input string req, input string what, input int id,
                     input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s u%0d %s: actual %0d expected %0d", req, id, what, got, exp);
    end
  endtask

  task automatic cmp_inst(input int id, input int n, input int es, input bit in_rst,
      input logic gv, input logic gz, input logic ge, input logic gs,
      input longint greg, input longint gexp, input longint gmant,
      input longint gflen, input longint gscale);
    ref_t e;
    string tv, tz, te, ts, tr, tx, tm, tc;
    e = applied_v ? ref_dec((id == 0) ? longint'(applied16) : longint'(applied8), n, es) : hold[id];
    tv = "R1"; tz = "R2"; te = "R3"; ts = "R4";
    tr = (e.regime >= 0) ? "R5" : "R6";
    tx = e.unterm ? "R7" : "R8";
    tm = e.unterm ? "R7" : "R9";
    tc = "R10";
    if (!applied_v) begin tz = "R11"; te = "R11"; ts = "R11"; tr = "R11"; tx = "R11"; tm = "R11"; tc = "R11"; end
    if (in_rst) begin tv = "R12"; tz = "R12"; te = "R12"; ts = "R12"; tr = "R12"; tx = "R12"; tm = "R12"; tc = "R12"; end
    cmp(tv, "valid", id, longint'(gv), longint'(applied_v));
    cmp(tz, "zero", id, longint'(gz), longint'(e.zero));
    cmp(te, "exc", id, longint'(ge), longint'(e.exc));
    cmp(ts, "sign", id, longint'(gs), longint'(e.sign));
    cmp(tr, "regime", id, greg, e.regime);
    cmp(tx, "exp", id, gexp, e.expo);
    cmp(tm, "mant", id, gmant, e.mant);
    cmp(tm, "flen", id, gflen, e.flen);
    cmp(tc, "scale", id, gscale, e.scale);
    if (applied_v) hold[id] = e;
  endtask

  task automatic check_all(input bit in_rst);
    cmp_inst(0, 16, 3, in_rst, v0, z0, e0, s0, longint'(r0), longint'(x0), longint'(m0), longint'(l0), longint'(c0));
    cmp_inst(1, 8, 0, in_rst, v1, z1, e1, s1, longint'(r1), longint'(x1), longint'(m1), longint'(l1), longint'(c1));
    cmp_inst(2, 8, 1, in_rst, v2, z2, e2, s2, longint'(r2), longint'(x2), longint'(m2), longint'(l2), longint'(c2));
    cmp_inst(3, 8, 2, in_rst, v3, z3, e3, s3, longint'(r3), longint'(x3), longint'(m3), longint'(l3), longint'(c3));
  endtask

  // Compare what the last edge produced, then present the next input
  task automatic step(input bit v, input logic [15:0] a16, input logic [7:0] a8);
    @(negedge clk);
    check_all(1'b0);
    applied_v = v;
    applied16 = a16;
    applied8  = a8;
    vin = v;
    w16 = a16;
    w8  = a8;
  endtask

  initial begin
    logic [15:0] dir [8];
    dir[0] = 16'h0000; dir[1] = 16'h8000; dir[2] = 16'h7FFF; dir[3] = 16'h0001;
    dir[4] = 16'hFFFF; dir[5] = 16'h8001; dir[6] = 16'h4000; dir[7] = 16'h3FFF;
    for (int k = 0; k < 4; k++) hold[k] = '0;
    // R12: reset state
    repeat (3) begin
      @(negedge clk);
      check_all(1'b1);
    end
    rst = 1'b0;
    // Every 8-bit code (R2..R10), directed then random 16-bit words
    for (int i = 0; i < 256; i++)
      step(1'b1, (i < 8) ? dir[i] : 16'($urandom), 8'(i));
    // Gaps in the qualifier exercise R1 and R11
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 16'($urandom), 8'($urandom));
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule